// File: doc/BRIEF.md
# Cascaded Serial Sink-Driver Chain Loader

This block sits on the host side of a string of cascaded sixteen-channel serial sink drivers. On a one-cycle start request it walks a frame buffer through a word-address/data port, one sixteen-bit word per device. It serializes the words onto a data line and a shift clock, then pulses latch-enable so every device copies its shift register into its output latches. A one-cycle done pulse marks the end of the frame.

Every interval on the serial side is a parameter counted in system-clock cycles. These are the data setup time before each rising shift-clock edge, the clock high time, the data hold time after the clock falls, the gap from the last rising edge to latch-enable, the latch-enable pulse width and the gap after latch-enable falls. The word for the farthest device is fetched first (address N-1) and each word leaves most significant bit first.

A bypass option serves chains whose latches are tied transparent. It drives the blanking output (active high, all outputs forced off) for the whole frame, and never for less than a programmable minimum width. The frame buffer is expected to answer an address with data one cycle later, as an inferred block RAM does.

Top module: `serial_chain_loader`

## Requirements
- R1: After reset, busy, done, ser_clk, ser_data, latch_en and blank are all low and word_addr is zero.
- R2: A start pulse while idle raises busy on the next cycle. The block reads words at addresses N_DEV-1 down to 0, and every rising edge of ser_clk for word k (counting from 0) occurs while word_addr equals N_DEV-1-k.
- R3: A frame produces exactly N_DEV*WORD_W rising ser_clk edges. Each word is sent bit WORD_W-1 first, so that the bits sampled on successive rising edges, concatenated, equal {word[N_DEV-1], ..., word[0]}.
- R4: ser_data changes no less than SETUP_CYC cycles before a rising ser_clk edge and no sooner than HOLD_CYC cycles after the falling edge. It never changes while ser_clk is high, and ser_clk stays high for exactly HIGH_CYC cycles.
- R5: latch_en rises exactly HIGH_CYC+HOLD_CYC+GAP_CYC cycles after the last rising ser_clk edge of the frame.
- R6: latch_en stays high for exactly LATCH_CYC cycles and is never high while ser_clk is high.
- R7: done is high for exactly one cycle, POST_CYC cycles after latch_en falls, and busy falls on that same cycle.
- R8: A start pulse while busy is ignored: the frame in progress keeps its address sequence and edge count, and only one done pulse results.
- R9: In bypass mode blank rises on the cycle busy rises, is high at every rising ser_clk edge, falls on the done cycle, and stays high for at least BLANK_MIN cycles.
- R10: In normal mode blank stays low throughout the frame.
- R11: ser_clk idles low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle frame request, honoured only when idle |
| bypass_mode | input | 1 | Blank outputs for the whole frame (transparent-latch chains), sampled at start |
| word_addr | output | $clog2(N_DEV) | Frame buffer word address |
| word_data | input | WORD_W | Frame buffer read data, valid one cycle after word_addr |
| ser_data | output | 1 | Serial data to the first device of the chain |
| ser_clk | output | 1 | Shift clock, idles low |
| latch_en | output | 1 | Latch-enable pulse after the last bit |
| blank | output | 1 | Output-enable (active high = all outputs off) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the timing edges around the shift clock. A design that moved data on the same cycle as a clock edge would show up as a zero-cycle setup or hold count. A design that closed the word loop one bit early or late would give an edge count other than N_DEV*WORD_W and a scrambled captured frame. Patterns that are all zeros, all ones, a walking one and alternating bits expose swapped word order and reversed bit order. The bench also fires a second start in the middle of a frame, which catches a design that restarts the address count or emits a second done. Bypass runs check that blanking covers every clock edge and ends exactly with done.

// File: rtl/chain_loader_pkg.sv
package chain_loader_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FETCH,
    S_CAPT,
    S_SETUP,
    S_HIGH,
    S_HOLD,
    S_GAP,
    S_LATCH,
    S_POST
  } phase_e;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/chain_phase_timer.sv
module chain_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R4: a running count never wraps past zero
  a_r4_timer_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load && expired) |=> expired);

endmodule

// File: rtl/chain_bit_shifter.sv
module chain_bit_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  input  logic              shift,
  output logic              sout,
  output logic              last
);

  localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [WORD_W-1:0] shreg;
  logic [BW-1:0]     bitcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      bitcnt <= '0;
    end else if (load) begin
      shreg  <= din;
      bitcnt <= '0;
    end else if (shift) begin
      shreg  <= {shreg[WORD_W-2:0], 1'b0};
      bitcnt <= bitcnt + 1'b1;
    end
  end

  assign sout = shreg[WORD_W-1];
  assign last = (bitcnt == BW'(WORD_W-1));

  // R3: a word is never loaded and shifted in the same cycle
  a_r3_no_load_and_shift: assert property (@(posedge clk) disable iff (rst)
    !(load && shift));

  // R3: no shift beyond the final bit of a word
  a_r3_no_shift_past_last: assert property (@(posedge clk) disable iff (rst)
    last |-> !shift);

endmodule

// File: rtl/serial_chain_loader.sv
module serial_chain_loader
  import chain_loader_pkg::*;
#(
  parameter int N_DEV     = 3,
  parameter int WORD_W    = 16,
  parameter int SETUP_CYC = 2,
  parameter int HIGH_CYC  = 2,
  parameter int HOLD_CYC  = 1,
  parameter int GAP_CYC   = 2,
  parameter int LATCH_CYC = 3,
  parameter int POST_CYC  = 2,
  parameter int BLANK_MIN = 8,
  localparam int AW = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              bypass_mode,
  output logic [AW-1:0]     word_addr,
  input  logic [WORD_W-1:0] word_data,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              latch_en,
  output logic              blank,
  output logic              busy,
  output logic              done
);

  localparam int T_MAX = imax(imax(imax(SETUP_CYC, HIGH_CYC), imax(HOLD_CYC, GAP_CYC)),
                              imax(LATCH_CYC, POST_CYC));
  localparam int TW    = $clog2(T_MAX + 1);
  localparam int BCW   = $clog2(BLANK_MIN + 1);

  phase_e          state, nxt;
  logic            t_load, t_exp;
  logic [TW-1:0]   t_val;
  logic            sh_load, sh_shift, sh_last;
  logic            addr_init, addr_dec;
  logic            bypass_q;
  logic [BCW-1:0]  blank_cnt;
  logic            blank_ok;

  chain_phase_timer #(.CNT_W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  chain_bit_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk(clk), .rst(rst), .load(sh_load), .din(word_data),
    .shift(sh_shift), .sout(ser_data), .last(sh_last)
  );

  assign blank_ok = !bypass_q || (blank_cnt >= BCW'(BLANK_MIN - 1));

  always_comb begin
    nxt       = state;
    t_load    = 1'b0;
    t_val     = '0;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    addr_init = 1'b0;
    addr_dec  = 1'b0;
    unique case (state)
      S_IDLE:  if (start) begin nxt = S_FETCH; addr_init = 1'b1; end
      S_FETCH: nxt = S_CAPT;
      S_CAPT: begin
        nxt = S_SETUP; sh_load = 1'b1; t_load = 1'b1; t_val = TW'(SETUP_CYC - 1);
      end
      S_SETUP: if (t_exp) begin
        nxt = S_HIGH; t_load = 1'b1; t_val = TW'(HIGH_CYC - 1);
      end
      S_HIGH: if (t_exp) begin
        nxt = S_HOLD; t_load = 1'b1; t_val = TW'(HOLD_CYC - 1);
      end
      S_HOLD: if (t_exp) begin
        if (!sh_last) begin
          nxt = S_SETUP; sh_shift = 1'b1; t_load = 1'b1; t_val = TW'(SETUP_CYC - 1);
        end else if (word_addr != '0) begin
          nxt = S_FETCH; addr_dec = 1'b1;
        end else begin
          nxt = S_GAP; t_load = 1'b1; t_val = TW'(GAP_CYC - 1);
        end
      end
      S_GAP: if (t_exp) begin
        nxt = S_LATCH; t_load = 1'b1; t_val = TW'(LATCH_CYC - 1);
      end
      S_LATCH: if (t_exp) begin
        nxt = S_POST; t_load = 1'b1; t_val = TW'(POST_CYC - 1);
      end
      S_POST: if (t_exp && blank_ok) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      word_addr <= '0;
      bypass_q  <= 1'b0;
      blank_cnt <= '0;
      ser_clk   <= 1'b0;
      latch_en  <= 1'b0;
      blank     <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      state    <= nxt;
      ser_clk  <= (nxt == S_HIGH);
      latch_en <= (nxt == S_LATCH);
      busy     <= (nxt != S_IDLE);
      done     <= (state == S_POST) && (nxt == S_IDLE);
      blank    <= (nxt != S_IDLE) && ((state == S_IDLE) ? bypass_mode : bypass_q);
      if (state == S_IDLE && start) bypass_q <= bypass_mode;
      if (addr_init)     word_addr <= AW'(N_DEV - 1);
      else if (addr_dec) word_addr <= word_addr - 1'b1;
      if (state == S_IDLE)                                  blank_cnt <= '0;
      else if (blank && blank_cnt < BCW'(BLANK_MIN))         blank_cnt <= blank_cnt + 1'b1;
    end
  end

  // R4: data holds still while the shift clock is high and on its fall
  a_r4_data_stable_high: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> $stable(ser_data));
  a_r4_data_hold_at_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_clk) |-> $stable(ser_data));

  // R6: latch-enable and shift clock never overlap
  a_r6_latch_clk_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ser_clk && latch_en));

  // R7: done lasts one cycle and coincides with the end of busy
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8: a start while busy leaves the address walk undisturbed
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start && state != S_HOLD) |=> $stable(word_addr));

  // R9: every shift clock pulse of a bypass frame sits inside blanking
  a_r9_blank_covers_clk: assert property (@(posedge clk) disable iff (rst)
    (ser_clk && bypass_q) |-> blank);

  // R11: the shift clock is low whenever the block is idle
  a_r11_clk_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ser_clk);

endmodule

// File: tb/serial_chain_loader_bench.sv
module serial_chain_loader_bench;

  localparam int N_DEV     = 3;
  localparam int WORD_W    = 16;
  localparam int SETUP_CYC = 2;
  localparam int HIGH_CYC  = 2;
  localparam int HOLD_CYC  = 1;
  localparam int GAP_CYC   = 2;
  localparam int LATCH_CYC = 3;
  localparam int POST_CYC  = 2;
  localparam int BLANK_MIN = 8;
  localparam int AW        = (N_DEV > 1) ? $clog2(N_DEV) : 1;
  localparam int NBITS     = N_DEV * WORD_W;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, bypass_mode = 1'b0;
  logic [AW-1:0]     word_addr;
  logic [WORD_W-1:0] word_data;
  logic ser_data, ser_clk, latch_en, blank, busy, done;

  logic [WORD_W-1:0] mem [N_DEV];

  always #4 clk = ~clk;

  always @(posedge clk) word_data <= mem[word_addr];

  serial_chain_loader #(
    .N_DEV(N_DEV), .WORD_W(WORD_W), .SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC),
    .HOLD_CYC(HOLD_CYC), .GAP_CYC(GAP_CYC), .LATCH_CYC(LATCH_CYC),
    .POST_CYC(POST_CYC), .BLANK_MIN(BLANK_MIN)
  ) u_serial_chain_loader (
    .clk(clk), .rst(rst), .start(start), .bypass_mode(bypass_mode),
    .word_addr(word_addr), .word_data(word_data), .ser_data(ser_data),
    .ser_clk(ser_clk), .latch_en(latch_en), .blank(blank), .busy(busy), .done(done)
  );

  int checks = 0, fails = 0;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: sampled on the falling system-clock edge
  int cyc = 0, rises, setup_bad, high_bad, hold_bad, addr_bad, blank_bad, overlap_bad;
  int le_delay, le_width, done_delay, done_cnt, done_long, busy_bad, idle_clk_bad;
  int last_rise, last_fall, last_chg, le_rise, le_fall, blank_rise, blank_fall, busy_rise;
  int done_cyc, blank_seen;
  logic [NBITS-1:0] cap;
  logic p_clk = 0, p_dat = 0, p_le = 0, p_done = 0, p_blank = 0, p_busy = 0;

  task automatic clear_stats();
    rises = 0; setup_bad = 0; high_bad = 0; hold_bad = 0; addr_bad = 0; blank_bad = 0;
    overlap_bad = 0; le_delay = -1; le_width = -1; done_delay = -1; done_cnt = 0;
    done_long = 0; busy_bad = 0; idle_clk_bad = 0; blank_rise = -1; blank_fall = -1;
    busy_rise = -2; done_cyc = -3; blank_seen = 0; cap = '0;
  endtask

  initial begin
    last_rise = -1000; last_fall = -1000; last_chg = -1000; le_rise = 0; le_fall = 0;
    clear_stats();
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (ser_data !== p_dat) begin
        if (ser_clk || (cyc - last_fall < HOLD_CYC)) hold_bad++;
        last_chg = cyc;
      end
      if (ser_clk && !p_clk) begin
        rises++;
        cap = {cap[NBITS-2:0], ser_data};
        if (cyc - last_chg < SETUP_CYC) setup_bad++;
        if (int'(word_addr) != N_DEV - 1 - (rises - 1) / WORD_W) addr_bad++;
        if (bypass_mode && !blank) blank_bad++;
        last_rise = cyc;
      end
      if (!ser_clk && p_clk) begin
        if (cyc - last_rise != HIGH_CYC) high_bad++;
        last_fall = cyc;
      end
      if (latch_en && !p_le) begin le_delay = cyc - last_rise; le_rise = cyc; end
      if (!latch_en && p_le) begin le_width = cyc - le_rise; le_fall = cyc; end
      if (ser_clk && latch_en) overlap_bad++;
      if (!busy && ser_clk) idle_clk_bad++;
      if (busy && !p_busy) busy_rise = cyc;
      if (done) begin
        done_cnt++;
        done_delay = cyc - le_fall;
        done_cyc = cyc;
        if (p_done) done_long++;
        if (busy) busy_bad++;
      end
      if (blank) blank_seen = 1;
      if (blank && !p_blank) blank_rise = cyc;
      if (!blank && p_blank) blank_fall = cyc;
    end
    p_clk = ser_clk; p_dat = ser_data; p_le = latch_en; p_done = done;
    p_blank = blank; p_busy = busy;
  end

  task automatic pulse_start();
    @(negedge clk); #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      if (done_cnt != 0) break;
    end
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic check_frame(input string tag);
    logic [NBITS-1:0] exp_cap;
    for (int i = 0; i < N_DEV; i++) exp_cap[i*WORD_W +: WORD_W] = mem[i];
    chk(rises == NBITS, {tag, " R3 edge count"}, rises, NBITS);
    chk(cap == exp_cap, {tag, " R3 captured frame"}, cap, exp_cap);
    chk(addr_bad == 0, {tag, " R2 address per word"}, addr_bad, 0);
    chk(setup_bad == 0 && hold_bad == 0, {tag, " R4 setup/hold"}, setup_bad + hold_bad, 0);
    chk(high_bad == 0, {tag, " R4 clock high width"}, high_bad, 0);
    chk(le_delay == HIGH_CYC + HOLD_CYC + GAP_CYC, {tag, " R5 latch gap"}, le_delay,
        HIGH_CYC + HOLD_CYC + GAP_CYC);
    chk(le_width == LATCH_CYC && overlap_bad == 0, {tag, " R6 latch width"}, le_width, LATCH_CYC);
    chk(done_cnt == 1 && done_long == 0 && busy_bad == 0, {tag, " R7 done pulse"}, done_cnt, 1);
    chk(done_delay == POST_CYC && !busy, {tag, " R7 post gap"}, done_delay, POST_CYC);
    chk(idle_clk_bad == 0 && !ser_clk, {tag, " R11 clock idle low"}, idle_clk_bad, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk({busy, done, ser_clk, ser_data, latch_en, blank} == 6'b0, "R1 outputs in reset",
        {busy, done, ser_clk, ser_data, latch_en, blank}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk({busy, done, ser_clk, latch_en, blank} == 5'b0, "R1 idle after reset",
        {busy, done, ser_clk, latch_en, blank}, 0);
    chk(word_addr == '0, "R1 address zero", word_addr, 0);
  endtask

  task automatic t_pattern(input string tag, input logic [WORD_W-1:0] w2,
                           input logic [WORD_W-1:0] w1, input logic [WORD_W-1:0] w0);
    mem[2] = w2; mem[1] = w1; mem[0] = w0;
    bypass_mode = 1'b0;
    clear_stats();
    pulse_start();
    chk(busy, {tag, " R2 busy after start"}, busy, 1);
    wait_done();
    check_frame(tag);
    chk(blank_seen == 0, {tag, " R10 no blank in normal mode"}, blank_seen, 0);
  endtask

  task automatic t_bypass();
    mem[2] = 16'h8001; mem[1] = 16'h7FFE; mem[0] = 16'h3C5A;
    bypass_mode = 1'b1;
    clear_stats();
    pulse_start();
    wait_done();
    check_frame("bypass");
    chk(blank_bad == 0, "R9 blank at every clock edge", blank_bad, 0);
    chk(blank_rise == busy_rise, "R9 blank rises with busy", blank_rise, busy_rise);
    chk(blank_fall == done_cyc, "R9 blank falls with done", blank_fall, done_cyc);
    chk(blank_fall - blank_rise >= BLANK_MIN, "R9 blank min width", blank_fall - blank_rise, BLANK_MIN);
    bypass_mode = 1'b0;
  endtask

  task automatic t_busy_start();
    mem[2] = 16'hC3A5; mem[1] = 16'h0F0F; mem[0] = 16'h9E37;
    bypass_mode = 1'b0;
    clear_stats();
    pulse_start();
    repeat (40) @(negedge clk);
    pulse_start();
    repeat (120) @(negedge clk);
    pulse_start();
    wait_done();
    repeat (150) @(negedge clk);
    #1;
    chk(done_cnt == 1, "R8 single done despite extra starts", done_cnt, 1);
    chk(!busy, "R8 idle after frame", busy, 0);
    check_frame("busy-start R8");
  endtask

  initial begin
    for (int i = 0; i < N_DEV; i++) mem[i] = '0;
    t_reset();
    t_pattern("alternating", 16'hA5A5, 16'h5A5A, 16'hFF00);
    t_pattern("walking-one", 16'h8000, 16'h0001, 16'h0100);
    t_pattern("all-ones", 16'hFFFF, 16'hFFFF, 16'hFFFF);
    t_pattern("all-zeros", 16'h0000, 16'h0000, 16'h0000);
    t_bypass();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule